// File: doc/BRIEF.md
# Four-Step Block-Matching Motion Search

This block finds the best integer displacement of one 4x4 pixel block inside a 20x20 pixel reference area. The current block and the reference area are first written into internal storage through a single write port. A select bit chooses between the two stores, and an address picks the pixel. A one-cycle start pulse then launches a search. The search visits candidate displacements in a coarse-to-fine pattern. It reports a signed motion vector, the matching cost at that vector, and a one-cycle completion pulse.

The search opens with a coarse pattern of spacing 2. It then repeats that coarse pattern around the running best point for as long as the best point keeps moving, up to a fixed limit. It closes with a fine pattern of spacing 1. In a repeat pass the search evaluates only the positions that the previous pattern did not cover. Each candidate is scored in a single cycle by a sum-of-absolute-differences unit. A controller walks the nine pattern slots of each step in a fixed order and keeps a candidate only if its cost is strictly lower than the running best.

Top module: `fss_motion_search`

## Requirements
- R1: After reset, busy and done are 0, the motion vector is (0,0) and the reported cost is 0.
- R2: A write with selWrite=0 stores pixel (row,col) of the current block at address row*4+col. A write with selWrite=1 stores pixel (row,col) of the reference area at address row*20+col. Displacement (dx,dy) compares the current block with the 4x4 reference window whose top-left pixel is at row 8+dy, column 8+dx.
- R3: The reported cost is the sum of absolute differences over the 16 pixel pairs of the reported displacement. The cost is held in 12 bits and cannot overflow, so the maximum of 16*255 = 4080 is reported exactly.
- R4: The first step scores the nine points with offsets -2, 0 and +2 on each axis around (0,0). If (0,0) is still best after that step, the search goes straight to the fine step.
- R5: A repeat coarse pass is centred on the current best point and scores only the points outside the previous pattern. That is five new points after a diagonal move and three new points after a move along one axis.
- R6: The coarse pass repeats while the best point moves, but at most two times after the first step. The running best cost never increases during a search.
- R7: The fine step scores the eight neighbours at offsets -1, 0 and +1 around the best point. Any candidate with a component outside -7..+7 is skipped, so both reported components lie in -7..+7.
- R8: Within each step the points are visited in raster order, top row first and left to right, after the centre. On equal costs the earlier point is kept, so (0,0) wins any tie with it.
- R9: busy is 1 from the cycle after an accepted start until done. done is high for exactly one cycle per search. A start pulse that arrives while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Pixel write strobe |
| selWrite | input | 1 | 0 selects the current-block store, 1 selects the reference store |
| wrAddr | input | 9 | Pixel address within the selected store |
| wrData | input | 8 | Unsigned pixel value |
| start | input | 1 | One-cycle pulse that launches a search when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| mvX | output | 4 | Signed horizontal displacement of the best match |
| mvY | output | 4 | Signed vertical displacement of the best match |
| minCost | output | 12 | Sum of absolute differences at the reported displacement |

## Verification
The assertions check the following on every cycle:
- the count of new points in each repeat pass (five after a diagonal move, three after a straight one);
- the limit on coarse passes;
- the jump from an unmoved first step to the fine step;
- that the running best cost never rises;
- that the vector stays inside the window;
- the single-cycle done pulse.

Only the bench scenarios can show that the vector and cost reached are the right ones. The bench checks this on cone-shaped reference areas whose minima lie at several displacements, including the window edge, and on random content. It also covers flat content that forces ties, saturated content that reaches the cost ceiling, and a stray start pulse issued in the middle of a search.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int PIX_W     = 8;
  localparam int BLK       = 4;
  localparam int REGION    = 20;
  localparam int RANGE     = 7;
  localparam int MAX_WIDE  = 2;
  localparam int CUR_N     = BLK * BLK;
  localparam int REF_N     = REGION * REGION;
  localparam int ORIGIN    = (REGION - BLK) / 2;
  localparam int MV_W      = $clog2(RANGE + 1) + 1;
  localparam int COST_W    = PIX_W + $clog2(CUR_N);
  localparam int ADDR_W    = $clog2(REF_N);
  localparam int CUR_AW    = $clog2(CUR_N);

  typedef logic signed [MV_W-1:0] mv_t;
  typedef logic [COST_W-1:0] cost_t;
  typedef logic [CUR_N-1:0][PIX_W-1:0] pixVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;     // score this candidate
    logic forceLoad;  // first candidate of a search seeds the best
    mv_t  candX;
    mv_t  candY;
  } dpStrobe_t;

  function automatic logic [PIX_W-1:0] absDiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/fss_sad.sv
module fss_sad
  import fss_pkg::*;
(
  input  pixVec_t curPix,
  input  pixVec_t winPix,
  output cost_t   sad
);
  logic [CUR_N-1:0][PIX_W-1:0] lane;

  for (genvar i = 0; i < CUR_N; i++) begin : gLane
    assign lane[i] = absDiff(curPix[i], winPix[i]);
  end

  always_comb begin
    sad = '0;
    for (int i = 0; i < CUR_N; i++) begin
      sad = sad + cost_t'(lane[i]);
    end
  end
endmodule

// File: rtl/fss_datapath.sv
module fss_datapath
  import fss_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              selWrite,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PIX_W-1:0]  wrData,
  input  dpStrobe_t         strobe,
  output mv_t               bestX,
  output mv_t               bestY,
  output cost_t             bestCost
);
  logic [PIX_W-1:0] curMem [CUR_N];
  logic [PIX_W-1:0] refMem [REF_N];
  pixVec_t curFlat, winFlat;
  cost_t candCost;

  always_ff @(posedge clk) begin
    if (wrEn && !selWrite && (int'(wrAddr) < CUR_N))
      curMem[wrAddr[CUR_AW-1:0]] <= wrData;
    if (wrEn && selWrite && (int'(wrAddr) < REF_N))
      refMem[wrAddr] <= wrData;
  end

  // gather the candidate window; any 4-bit candidate stays inside the area
  for (genvar r = 0; r < BLK; r++) begin : gRow
    for (genvar c = 0; c < BLK; c++) begin : gCol
      logic [ADDR_W-1:0] pixAddr;
      assign pixAddr = ADDR_W'((ORIGIN + r + int'($signed(strobe.candY))) * REGION
                               + ORIGIN + c + int'($signed(strobe.candX)));
      assign winFlat[r*BLK+c] = refMem[pixAddr];
      assign curFlat[r*BLK+c] = curMem[r*BLK+c];
    end
  end

  fss_sad sad_i (
    .curPix(curFlat),
    .winPix(winFlat),
    .sad   (candCost)
  );

  // strict compare keeps the earlier candidate on ties
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestX    <= '0;
      bestY    <= '0;
      bestCost <= '0;
    end else if (strobe.evalEn && (strobe.forceLoad || (candCost < bestCost))) begin
      bestX    <= strobe.candX;
      bestY    <= strobe.candY;
      bestCost <= candCost;
    end
  end

  assert_cost_monotone_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evalEn && !strobe.forceLoad) |=> (bestCost <= $past(bestCost)));

  assert_mv_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bestX >= -RANGE) && (bestX <= RANGE) && (bestY >= -RANGE) && (bestY <= RANGE));
endmodule

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  mv_t       bestX,
  input  mv_t       bestY,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int WW = MV_W + 2;
  typedef logic signed [WW-1:0] wide_t;
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DECIDE, S_FINISH} state_t;
  typedef enum logic [1:0] {K_FIRST, K_WIDE, K_FINE} kind_t;

  state_t state;
  kind_t  kind;
  logic [3:0] idx;
  mv_t    ctrX, ctrY;
  wide_t  prevShX, prevShY;
  logic [1:0] widePasses;

  wide_t offX, offY, stride, cX, cY, reachX, reachY, shX, shY;
  logic  inWin, alreadySeen, moved;
  int    slotI;

  always_comb begin
    slotI = (idx < 4'd5) ? int'(idx) - 1 : int'(idx);
    if (idx == 4'd0) begin
      offX = '0;
      offY = '0;
    end else begin
      offX = wide_t'(slotI % 3 - 1);
      offY = wide_t'(slotI / 3 - 1);
    end
    stride = (kind == K_FINE) ? wide_t'(1) : wide_t'(2);
    cX = wide_t'(ctrX) + offX * stride;
    cY = wide_t'(ctrY) + offY * stride;
    inWin = (cX >= -RANGE) && (cX <= RANGE) && (cY >= -RANGE) && (cY <= RANGE);
    // position relative to the previous coarse centre
    reachX = prevShX + offX * wide_t'(2);
    reachY = prevShY + offY * wide_t'(2);
    unique case (kind)
      K_WIDE:  alreadySeen = (reachX >= -2) && (reachX <= 2) && (reachY >= -2) && (reachY <= 2);
      K_FINE:  alreadySeen = (idx == 4'd0);
      default: alreadySeen = 1'b0;
    endcase
    strobe.evalEn    = (state == S_EVAL) && inWin && !alreadySeen;
    strobe.forceLoad = (kind == K_FIRST) && (idx == 4'd0);
    strobe.candX     = mv_t'(cX);
    strobe.candY     = mv_t'(cY);
    shX   = wide_t'(bestX) - wide_t'(ctrX);
    shY   = wide_t'(bestY) - wide_t'(ctrY);
    moved = (shX != 0) || (shY != 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      kind       <= K_FIRST;
      idx        <= '0;
      ctrX       <= '0;
      ctrY       <= '0;
      prevShX    <= '0;
      prevShY    <= '0;
      widePasses <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          kind       <= K_FIRST;
          ctrX       <= '0;
          ctrY       <= '0;
          prevShX    <= '0;
          prevShY    <= '0;
          widePasses <= '0;
          idx        <= '0;
          state      <= S_EVAL;
        end
        S_EVAL: begin
          if (idx == 4'd8) begin
            idx   <= '0;
            state <= S_DECIDE;
          end else begin
            idx <= idx + 4'd1;
          end
        end
        S_DECIDE: begin
          ctrX    <= bestX;
          ctrY    <= bestY;
          prevShX <= shX;
          prevShY <= shY;
          state   <= S_EVAL;
          unique case (kind)
            K_FIRST: begin
              if (moved) begin
                kind       <= K_WIDE;
                widePasses <= 2'd1;
              end else begin
                kind <= K_FINE;
              end
            end
            K_WIDE: begin
              if (moved && (int'(widePasses) < MAX_WIDE))
                widePasses <= widePasses + 2'd1;
              else
                kind <= K_FINE;
            end
            default: state <= S_FINISH;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FINISH);

  // checker-only count of points outside the previous coarse pattern
  logic [3:0] newCount;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) newCount <= '0;
    else if (state != S_EVAL) newCount <= '0;
    else if (kind == K_WIDE && !alreadySeen) newCount <= newCount + 4'd1;
  end

  assert_new_points_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECIDE && kind == K_WIDE) |->
      (newCount == (((prevShX != 0) && (prevShY != 0)) ? 4'd5 : 4'd3)));

  assert_pass_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(widePasses) <= MAX_WIDE);

  assert_center_skip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECIDE && kind == K_FIRST && bestX == 0 && bestY == 0) |=> (kind == K_FINE));
endmodule

// File: rtl/fss_motion_search.sv
module fss_motion_search
  import fss_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     selWrite,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [PIX_W-1:0]         wrData,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic signed [MV_W-1:0]   mvX,
  output logic signed [MV_W-1:0]   mvY,
  output logic [COST_W-1:0]        minCost
);
  dpStrobe_t strobe;
  mv_t bestX, bestY;
  cost_t bestCost;

  fss_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .bestX (bestX),
    .bestY (bestY),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  fss_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .selWrite(selWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .strobe  (strobe),
    .bestX   (bestX),
    .bestY   (bestY),
    .bestCost(bestCost)
  );

  assign mvX     = bestX;
  assign mvY     = bestY;
  assign minCost = bestCost;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/fss_motion_search_tb_top.sv
module fss_motion_search_tb_top;
  import fss_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrEn, selWrite, start, busy, done;
  logic [ADDR_W-1:0] wrAddr;
  logic [PIX_W-1:0] wrData;
  logic signed [MV_W-1:0] mvX, mvY;
  logic [COST_W-1:0] minCost;

  fss_motion_search dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .selWrite(selWrite), .wrAddr(wrAddr),
    .wrData(wrData), .start(start), .busy(busy), .done(done),
    .mvX(mvX), .mvY(mvY), .minCost(minCost)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int curA [CUR_N];
  int refA [REF_N];
  int seed = 12345;

  always @(posedge clk) cycles++;

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  function automatic int sadAt(input int dx, input int dy);
    int s = 0;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        s += iabs(curA[r*BLK+c] - refA[(ORIGIN+dy+r)*REGION + ORIGIN+dx+c]);
    return s;
  endfunction

  // expected search outcome computed from the requirements
  task automatic model(output int ex, output int ey, output int ec);
    int cx = 0, cy = 0, px = 0, py = 0, bx = 0, by = 0, bc, kind = 0, passes = 0;
    int stride, ox, oy, x, y, c, mx, my;
    bc = sadAt(0, 0);
    while (1) begin
      stride = (kind == 2) ? 1 : 2;
      for (int k = 0; k < 9; k++) begin
        if (k == 4) continue;
        ox = k % 3 - 1;
        oy = k / 3 - 1;
        x = cx + ox * stride;
        y = cy + oy * stride;
        if (iabs(x) > RANGE || iabs(y) > RANGE) continue;
        if (kind == 1 && iabs(cx - px + 2*ox) <= 2 && iabs(cy - py + 2*oy) <= 2) continue;
        c = sadAt(x, y);
        if (c < bc) begin bc = c; bx = x; by = y; end
      end
      if (kind == 2) break;
      mx = bx - cx;
      my = by - cy;
      if (kind == 0) begin
        if (mx != 0 || my != 0) begin kind = 1; passes = 1; end
        else kind = 2;
      end else begin
        if ((mx != 0 || my != 0) && passes < MAX_WIDE) passes++;
        else kind = 2;
      end
      px = cx; py = cy; cx = bx; cy = by;
    end
    ex = bx; ey = by; ec = bc;
  endtask

  task automatic writePix(input bit sel, input int addr, input int val);
    @(negedge clk);
    wrEn = 1'b1;
    selWrite = sel;
    wrAddr = ADDR_W'(addr);
    wrData = PIX_W'(val);
  endtask

  task automatic loadAll();
    for (int i = 0; i < CUR_N; i++) writePix(1'b0, i, curA[i]);
    for (int i = 0; i < REF_N; i++) writePix(1'b1, i, refA[i]);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runSearch(input string req, output bit ok);
    int t = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(req, "busy after start", int'(busy), 1);
    while (!done && t < 400) begin
      @(negedge clk);
      t++;
    end
    ok = done;
    chk(req, "done seen", int'(done), 1);
  endtask

  task automatic checkResult(input string req);
    int ex, ey, ec;
    model(ex, ey, ec);
    chk(req, "mvX", int'(mvX), ex);
    chk(req, "mvY", int'(mvY), ey);
    chk(req, "cost", int'(minCost), ec);
    chk("R3", "cost equals SAD at reported vector", int'(minCost), sadAt(int'(mvX), int'(mvY)));
    chk("R7", "vector inside window", int'(iabs(int'(mvX)) <= RANGE && iabs(int'(mvY)) <= RANGE), 1);
    @(negedge clk);
    chk("R9", "done lasts one cycle", int'(done), 0);
    chk("R9", "busy cleared", int'(busy), 0);
  endtask

  task automatic fillCone(input int tx, input int ty);
    int v;
    for (int y = 0; y < REGION; y++)
      for (int x = 0; x < REGION; x++) begin
        v = 200 - 6 * (iabs(x - (ORIGIN + tx)) + iabs(y - (ORIGIN + ty)));
        refA[y*REGION+x] = (v < 0) ? 0 : v;
      end
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        curA[r*BLK+c] = refA[(ORIGIN+ty+r)*REGION + ORIGIN+tx+c];
  endtask

  task automatic testReset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "mvX", int'(mvX), 0);
    chk("R1", "mvY", int'(mvY), 0);
    chk("R1", "cost", int'(minCost), 0);
  endtask

  task automatic testCone(input int tx, input int ty, input bit exact);
    bit ok;
    fillCone(tx, ty);
    loadAll();
    runSearch("R2", ok);
    if (exact) begin
      chk("R2", "cone apex x", int'(mvX), tx);
      chk("R2", "cone apex y", int'(mvY), ty);
      chk("R4", "zero cost at apex", int'(minCost), 0);
    end
    checkResult("R5");
  endtask

  task automatic testFlat();
    bit ok;
    for (int i = 0; i < REF_N; i++) refA[i] = 77;
    for (int i = 0; i < CUR_N; i++) curA[i] = 90;
    loadAll();
    runSearch("R8", ok);
    chk("R8", "tie keeps centre x", int'(mvX), 0);
    chk("R8", "tie keeps centre y", int'(mvY), 0);
    chk("R8", "tie cost", int'(minCost), 16 * 13);
    checkResult("R8");
  endtask

  task automatic testMaxCost();
    bit ok;
    for (int i = 0; i < REF_N; i++) refA[i] = 0;
    for (int i = 0; i < CUR_N; i++) curA[i] = 255;
    loadAll();
    runSearch("R3", ok);
    chk("R3", "full-scale cost", int'(minCost), 4080);
    checkResult("R3");
  endtask

  task automatic testRandom(input int s);
    bit ok;
    seed = s;
    for (int i = 0; i < REF_N; i++) refA[i] = nextRand();
    for (int i = 0; i < CUR_N; i++) curA[i] = nextRand();
    loadAll();
    runSearch("R6", ok);
    checkResult("R6");
  endtask

  task automatic testStartWhileBusy();
    int t = 0, pulses = 0;
    fillCone(-5, 6);
    loadAll();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (t < 80) begin
      if (done) pulses++;
      if (done) break;
      @(negedge clk);
      t++;
    end
    checkResult("R9");
    t = 0;
    while (t < 60) begin
      if (done || busy) pulses++;
      @(negedge clk);
      t++;
    end
    chk("R9", "single completion for stray start", pulses, 1);
  endtask

  initial begin
    rstN = 1'b0;
    wrEn = 1'b0;
    selWrite = 1'b0;
    wrAddr = '0;
    wrData = '0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCone(0, 0, 1'b1);
    testCone(2, 2, 1'b1);
    testCone(-2, 0, 1'b1);
    testCone(5, -3, 1'b0);
    testCone(7, 7, 1'b0);
    testCone(-7, 1, 1'b0);
    testCone(3, 6, 1'b0);
    testFlat();
    testMaxCost();
    testRandom(11);
    testRandom(4242);
    testRandom(90001);
    testStartWhileBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule